// File: doc/BRIEF.md
# Host Processor Bus Slave Port

This block is a synchronous slave port through which an external 32-bit host processor reads and writes a small bank of internal registers. The host starts a cycle by raising a select strobe for one clock, together with a read/write flag, a two-bit transfer-size code, a byte address, write data and one odd-parity bit per byte lane. The port decodes the size and address into a set of active byte lanes, checks write parity on those lanes, and reaches the register bank. It then ends the cycle with exactly one active-low response: acknowledge, transfer-error acknowledge or retry.

The bus uses big-endian lane numbering. Lane 0 is the most significant byte and is addressed by byte offset 0. The register bank behind the port has two status inputs. A busy flag, sampled when a cycle starts, turns the cycle into a retry with no side effects. An error flag, sampled on the response edge, turns an otherwise good cycle into a transfer error. Read data is always returned with freshly generated parity, and any lane that is not read is driven as zero.

Top module: `hbus_slave`

## Requirements
- R1: Reset is synchronous and active high. After reset, `ack_n_o`, `tea_n_o` and `rtry_n_o` are 1, `rdata_o` is 0 and `rpar_o` is 4'b1111.
- R2: A cycle starts when `cs_i` is high at a rising edge while the port is idle. On the next rising edge exactly one of `ack_n_o`, `tea_n_o` or `rtry_n_o` goes low. It stays low for one clock, and all three are high in the clock after that.
- R3: `tsz_i` is decoded as 2'b01 for a byte, 2'b10 for a half-word and 2'b00 for a word. The code 2'b11 ends the cycle with `tea_n_o` low.
- R4: Lane k occupies data bits [31-8k:24-8k] and is covered by parity bit k. Byte offset `addr_i[1:0]`=k selects lane k for a byte transfer. A half-word at offset 0 uses lanes 0 and 1, and a half-word at offset 2 uses lanes 2 and 3. A word uses all four lanes.
- R5: A half-word at an odd offset, or a word at a nonzero offset, ends with `tea_n_o` low and writes nothing.
- R6: Parity is odd: an active lane's 8 data bits and its parity bit together hold an odd number of ones. A mismatch on any active write lane ends with `tea_n_o` low and blocks the whole write. Parity bits of inactive lanes are ignored.
- R7: An acknowledged write updates only the active lanes of register `addr_i[AW-1:2]`. All other lanes and registers keep their values.
- R8: On an acknowledged read, the active lanes of `rdata_o` carry the register contents and the inactive lanes are zero. Every bit of `rpar_o` is odd parity over its lane.
- R9: Whenever the port is not acknowledging a read, `rdata_o` is 0 and `rpar_o` is 4'b1111.
- R10: If `rb_busy_i` is high on the start edge, the cycle ends with `rtry_n_o` low and has no effect on the registers. This holds even when the request is also malformed or has bad parity.
- R11: If `rb_err_i` is high on the response edge (the first rising edge after the start edge) of an otherwise valid cycle, the cycle ends with `tea_n_o` low instead of `ack_n_o`, and a write is blocked.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| cs_i | input | 1 | Cycle start strobe |
| rnw_i | input | 1 | 1 = read, 0 = write |
| tsz_i | input | 2 | Transfer-size code |
| addr_i | input | AW (6) | Byte address; bits 1:0 pick lanes, upper bits pick the register |
| wdata_i | input | 32 | Write data from the host |
| wpar_i | input | 4 | Write parity, one bit per lane |
| rb_busy_i | input | 1 | Register bank busy, sampled on the start edge |
| rb_err_i | input | 1 | Register bank error, sampled on the response edge |
| rdata_o | output | 32 | Read data to the host |
| rpar_o | output | 4 | Read parity, one bit per lane |
| ack_n_o | output | 1 | Active-low acknowledge |
| tea_n_o | output | 1 | Active-low transfer-error acknowledge |
| rtry_n_o | output | 1 | Active-low retry request |

## Verification
On every cycle, the assertions check the timing shape of the handshake. At most one response strobe is low at a time, and each strobe is a single-clock pulse that follows a start strobe two edges earlier. A busy flag always leads to a retry, and an internal error never leads to an acknowledge. The read bus always carries odd parity and is zero outside a read acknowledge. Whether the right lanes were written, whether bad parity or misalignment really left a register untouched, and whether read data matches what was stored can only be shown by the bench. Its sweeps over every register, size code, offset and parity-fault lane read each register back after the write.

// File: rtl/hbus_pkg.sv
package hbus_pkg;

  localparam int BUS_W = 32;
  localparam int LANES = BUS_W / 8;

  typedef enum logic [1:0] {
    SZ_WORD = 2'b00,
    SZ_BYTE = 2'b01,
    SZ_HALF = 2'b10,
    SZ_RSVD = 2'b11
  } size_e;

  typedef enum logic [1:0] {
    RSP_ACK  = 2'b00,
    RSP_TEA  = 2'b01,
    RSP_RTRY = 2'b10
  } rsp_e;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_EXEC = 1'b1
  } state_e;

endpackage

// File: rtl/hbus_decode.sv
module hbus_decode
  import hbus_pkg::*;
(
  input  logic [1:0]       tsz_i,
  input  logic [1:0]       off_i,
  output logic [LANES-1:0] lanes_o,
  output logic             bad_o
);

  // Lane k is bit k of lanes_o; lane 0 is the most significant byte.
  always_comb begin
    lanes_o = '0;
    bad_o   = 1'b0;
    case (size_e'(tsz_i))
      SZ_BYTE: lanes_o[off_i] = 1'b1;
      SZ_HALF: begin
        if (off_i[0]) bad_o = 1'b1;
        else          lanes_o = off_i[1] ? 4'b1100 : 4'b0011;
      end
      SZ_WORD: begin
        if (off_i != 2'b00) bad_o = 1'b1;
        else                lanes_o = '1;
      end
      default: bad_o = 1'b1;
    endcase
  end

  // R4/R5: an accepted request always activates at least one lane
  always_comb begin
    if (!bad_o) a_r4_lanes_nonzero: assert (lanes_o != '0);
  end

endmodule

// File: rtl/hbus_parity.sv
module hbus_parity #(
  parameter int DW = 32,
  localparam int NL = DW / 8
) (
  input  logic [DW-1:0] data_i,
  output logic [NL-1:0] par_o
);

  // Odd parity per lane; lane k sits at bits [DW-1-8k -: 8]
  for (genvar k = 0; k < NL; k++) begin : g_lane
    assign par_o[k] = ~^data_i[DW-1-8*k -: 8];
  end

endmodule

// File: rtl/hbus_regbank.sv
module hbus_regbank #(
  parameter int DW   = 32,
  parameter int NREG = 16,
  localparam int IW  = $clog2(NREG),
  localparam int NL  = DW / 8
) (
  input  logic          clk,
  input  logic          re_i,
  input  logic [IW-1:0] ridx_i,
  output logic [DW-1:0] rdata_o,
  input  logic          we_i,
  input  logic [IW-1:0] widx_i,
  input  logic [NL-1:0] be_i,
  input  logic [DW-1:0] wdata_i
);

  logic [DW-1:0] mem [NREG];

  // Simple dual-port array with per-lane write enables and registered read
  always_ff @(posedge clk) begin
    if (we_i) begin
      for (int k = 0; k < NL; k++) begin
        if (be_i[k]) mem[widx_i][DW-1-8*k -: 8] <= wdata_i[DW-1-8*k -: 8];
      end
    end
    if (re_i) rdata_o <= mem[ridx_i];
  end

endmodule

// File: rtl/hbus_slave.sv
module hbus_slave
  import hbus_pkg::*;
#(
  parameter int NREG = 16,
  localparam int IW  = $clog2(NREG),
  localparam int AW  = IW + 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cs_i,
  input  logic             rnw_i,
  input  logic [1:0]       tsz_i,
  input  logic [AW-1:0]    addr_i,
  input  logic [BUS_W-1:0] wdata_i,
  input  logic [LANES-1:0] wpar_i,
  input  logic             rb_busy_i,
  input  logic             rb_err_i,
  output logic [BUS_W-1:0] rdata_o,
  output logic [LANES-1:0] rpar_o,
  output logic             ack_n_o,
  output logic             tea_n_o,
  output logic             rtry_n_o
);

  state_e           state_q;
  logic             start, exec, wr_en;
  logic [LANES-1:0] lanes_d, wgen, lanes_q, rpar_d;
  logic             bad_d, perr_d;
  logic             rnw_q, busy_q, fault_q;
  logic [IW-1:0]    idx_q;
  logic [BUS_W-1:0] wdata_q, rd_word, lane_bits, rdata_d;
  rsp_e             rsp;

  assign start = (state_q == ST_IDLE) && cs_i;
  assign exec  = (state_q == ST_EXEC);

  hbus_decode u_dec (
    .tsz_i   (tsz_i),
    .off_i   (addr_i[1:0]),
    .lanes_o (lanes_d),
    .bad_o   (bad_d)
  );

  hbus_parity #(.DW(BUS_W)) u_wpar (
    .data_i (wdata_i),
    .par_o  (wgen)
  );

  assign perr_d = !rnw_i && |(lanes_d & (wgen ^ wpar_i));

  // Sequencer: one start edge, one response edge
  always_ff @(posedge clk) begin
    if (rst)        state_q <= ST_IDLE;
    else if (start) state_q <= ST_EXEC;
    else if (exec)  state_q <= ST_IDLE;
  end

  // Request capture on the start edge
  always_ff @(posedge clk) begin
    if (start) begin
      rnw_q   <= rnw_i;
      busy_q  <= rb_busy_i;
      fault_q <= bad_d | perr_d;
      lanes_q <= lanes_d;
      idx_q   <= addr_i[AW-1:2];
      wdata_q <= wdata_i;
    end
  end

  always_comb begin
    if (busy_q)                  rsp = RSP_RTRY;
    else if (fault_q || rb_err_i) rsp = RSP_TEA;
    else                         rsp = RSP_ACK;
  end

  assign wr_en = exec && (rsp == RSP_ACK) && !rnw_q;

  hbus_regbank #(.DW(BUS_W), .NREG(NREG)) u_bank (
    .clk     (clk),
    .re_i    (start),
    .ridx_i  (addr_i[AW-1:2]),
    .rdata_o (rd_word),
    .we_i    (wr_en),
    .widx_i  (idx_q),
    .be_i    (lanes_q),
    .wdata_i (wdata_q)
  );

  for (genvar k = 0; k < LANES; k++) begin : g_mask
    assign lane_bits[BUS_W-1-8*k -: 8] = {8{lanes_q[k]}};
  end

  assign rdata_d = (exec && (rsp == RSP_ACK) && rnw_q) ? (rd_word & lane_bits) : '0;

  hbus_parity #(.DW(BUS_W)) u_rpar (
    .data_i (rdata_d),
    .par_o  (rpar_d)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      ack_n_o  <= 1'b1;
      tea_n_o  <= 1'b1;
      rtry_n_o <= 1'b1;
      rdata_o  <= '0;
      rpar_o   <= '1;
    end else begin
      ack_n_o  <= !(exec && (rsp == RSP_ACK));
      tea_n_o  <= !(exec && (rsp == RSP_TEA));
      rtry_n_o <= !(exec && (rsp == RSP_RTRY));
      rdata_o  <= rdata_d;
      rpar_o   <= rpar_d;
    end
  end

  // R2: response strobes are exclusive single-clock pulses tied to a start
  a_r2_one_strobe: assert property (@(posedge clk) disable iff (rst)
    $countones({!ack_n_o, !tea_n_o, !rtry_n_o}) <= 1);
  a_r2_ack_pulse: assert property (@(posedge clk) disable iff (rst)
    !ack_n_o |=> ack_n_o);
  a_r2_tea_pulse: assert property (@(posedge clk) disable iff (rst)
    !tea_n_o |=> tea_n_o);
  a_r2_rtry_pulse: assert property (@(posedge clk) disable iff (rst)
    !rtry_n_o |=> rtry_n_o);
  a_r2_origin: assert property (@(posedge clk) disable iff (rst)
    (!ack_n_o || !tea_n_o || !rtry_n_o) |-> $past(cs_i, 2));

  // R10: busy at the start edge decides retry
  a_r10_rtry_busy: assert property (@(posedge clk) disable iff (rst)
    !rtry_n_o |-> $past(rb_busy_i, 2));
  a_r10_no_ack_busy: assert property (@(posedge clk) disable iff (rst)
    !ack_n_o |-> !$past(rb_busy_i, 2));

  // R11: an internal error on the response edge never acknowledges
  a_r11_no_ack_err: assert property (@(posedge clk) disable iff (rst)
    !ack_n_o |-> !$past(rb_err_i));

  // R9: quiet read bus outside an acknowledge
  a_r9_quiet_bus: assert property (@(posedge clk) disable iff (rst)
    ack_n_o |-> (rdata_o == '0 && rpar_o == '1));

  // R8: every driven lane carries odd parity
  for (genvar k = 0; k < LANES; k++) begin : g_chk
    a_r8_odd_lane: assert property (@(posedge clk) disable iff (rst)
      (^{rdata_o[BUS_W-1-8*k -: 8], rpar_o[k]}) == 1'b1);
  end

endmodule

// File: tb/hbus_slave_tb.sv
module hbus_slave_tb;

  localparam int NREG = 16;
  localparam int AW   = 6;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cs = 1'b0, rnw = 1'b0, busy = 1'b0, ierr = 1'b0;
  logic [1:0]  tsz = 2'b00;
  logic [AW-1:0] addr = '0;
  logic [31:0] wdata = '0;
  logic [3:0]  wpar = '0;
  logic [31:0] rdata;
  logic [3:0]  rpar;
  logic        ack_n, tea_n, rtry_n;

  int n_chk  = 0;
  int n_fail = 0;
  logic [31:0] model [NREG];

  always #10 clk = ~clk;

  hbus_slave #(.NREG(NREG)) u_dut (
    .clk(clk), .rst(rst), .cs_i(cs), .rnw_i(rnw), .tsz_i(tsz), .addr_i(addr),
    .wdata_i(wdata), .wpar_i(wpar), .rb_busy_i(busy), .rb_err_i(ierr),
    .rdata_o(rdata), .rpar_o(rpar), .ack_n_o(ack_n), .tea_n_o(tea_n), .rtry_n_o(rtry_n)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // R4 lane sets, 0 when the request is invalid (R3, R5)
  function automatic logic [3:0] exp_lanes(input logic [1:0] sz, input logic [1:0] off);
    case (sz)
      2'b01:   return 4'b0001 << off;
      2'b10:   return (off == 2'd0) ? 4'b0011 : (off == 2'd2) ? 4'b1100 : 4'b0000;
      2'b00:   return (off == 2'd0) ? 4'b1111 : 4'b0000;
      default: return 4'b0000;
    endcase
  endfunction

  function automatic logic [31:0] lane_mask(input logic [3:0] l);
    logic [31:0] m = '0;
    for (int k = 0; k < 4; k++) m[31-8*k -: 8] = {8{l[k]}};
    return m;
  endfunction

  function automatic logic [3:0] opar(input logic [31:0] d);
    logic [3:0] p;
    for (int k = 0; k < 4; k++) p[k] = ~^d[31-8*k -: 8];
    return p;
  endfunction

  // Strobe code: 3'b100 ack, 3'b010 tea, 3'b001 retry
  task automatic op(input string req, input logic r, input logic [1:0] sz,
                    input logic [AW-1:0] a, input logic [31:0] d,
                    input logic [3:0] flip, input logic bz, input logic er);
    logic [3:0]  l;
    logic [2:0]  exp_s, got_s, rel;
    logic [31:0] exp_d, got_d;
    logic [3:0]  got_p;
    int idx;
    l   = exp_lanes(sz, a[1:0]);
    idx = int'(a[AW-1:2]);
    if (bz) exp_s = 3'b001;
    else if (l == 4'b0 || er || (!r && |(l & flip))) exp_s = 3'b010;
    else exp_s = 3'b100;
    exp_d = (exp_s == 3'b100 && r) ? (model[idx] & lane_mask(l)) : 32'h0;

    @(negedge clk);
    cs = 1'b1; rnw = r; tsz = sz; addr = a; wdata = d; wpar = opar(d) ^ flip; busy = bz;
    @(negedge clk);
    cs = 1'b0; busy = 1'b0; ierr = er;
    @(negedge clk);
    ierr = 1'b0;
    got_s = {!ack_n, !tea_n, !rtry_n};
    got_d = rdata;
    got_p = rpar;
    @(negedge clk);
    rel = {ack_n, tea_n, rtry_n};

    chk({req, " response"}, {29'b0, got_s}, {29'b0, exp_s});
    chk({req, " R8 R9 data"}, got_d, exp_d);
    chk({req, " R8 R9 parity"}, {28'b0, got_p}, {28'b0, opar(exp_d)});
    chk("R2 strobe released", {29'b0, rel}, 32'h7);
    if (exp_s == 3'b100 && !r)
      model[idx] = (model[idx] & ~lane_mask(l)) | (d & lane_mask(l));
  endtask

  task automatic readback(input int idx);
    op("R7 readback", 1'b1, 2'b00, AW'(idx << 2), 32'h0, 4'h0, 1'b0, 1'b0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk("R1 strobes", {29'b0, ack_n, tea_n, rtry_n}, 32'h7);
    chk("R1 rdata", rdata, 32'h0);
    chk("R1 rpar", {28'b0, rpar}, 32'hF);

    // Fill and read every register with word transfers
    for (int i = 0; i < NREG; i++)
      op("R7 word fill", 1'b0, 2'b00, AW'(i << 2), 32'h1357_9BDF * (i + 1), 4'h0, 1'b0, 1'b0);
    for (int i = 0; i < NREG; i++) readback(i);

    // R3 R4 R5: every size code and offset, reads and writes, on every register
    for (int i = 0; i < NREG; i++)
      for (int s = 0; s < 4; s++)
        for (int o = 0; o < 4; o++)
          for (int r = 0; r < 2; r++) begin
            op("R3 R4 R5 sweep", r[0], s[1:0], AW'((i << 2) | o),
               32'hA5C3_0F69 ^ (32'h0101_0101 * (i * 16 + s * 4 + o + 1)), 4'h0, 1'b0, 1'b0);
            if (r == 0) readback(i);
          end

    // R6: a single flipped parity lane on each valid transfer shape
    for (int s = 0; s < 3; s++)
      for (int o = 0; o < 4; o++)
        for (int f = 0; f < 4; f++) begin
          op("R6 parity", 1'b0, s[1:0], AW'((5 << 2) | o),
             32'h0F1E_2D3C + 32'(f * 77 + o * 9 + s), 4'b0001 << f, 1'b0, 1'b0);
          readback(5);
        end

    // R10: busy wins over everything, including bad size and bad parity
    op("R10 busy write", 1'b0, 2'b00, AW'(3 << 2), 32'hDEAD_BEEF, 4'h0, 1'b1, 1'b0);
    op("R10 busy read", 1'b1, 2'b00, AW'(3 << 2), 32'h0, 4'h0, 1'b1, 1'b0);
    op("R10 busy bad size", 1'b0, 2'b11, AW'(3 << 2), 32'h1111_2222, 4'hF, 1'b1, 1'b0);
    readback(3);

    // R11: internal error on the response edge
    op("R11 error write", 1'b0, 2'b10, AW'((7 << 2) | 2), 32'h7777_8888, 4'h0, 1'b0, 1'b1);
    op("R11 error read", 1'b1, 2'b00, AW'(7 << 2), 32'h0, 4'h0, 1'b0, 1'b1);
    readback(7);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule